// File: doc/BRIEF.md
# Keyed Nonvolatile Memory Control Front-End

This block sits between a processor's register bus and the back-end that actually programs or erases the on-chip nonvolatile program memory. Software sees a small bank of 32-bit registers: a control word, a write-only key port, a target address, a data word and a source address. The control and address registers can each be reached through four aliases that replace, clear, set or invert bits. A program or erase operation can only be launched after two exact key words have been written back to back. That protects the array against stray writes.

A launch hands the back-end a single-cycle start pulse, together with the operation code and the data and source words. It also hands over a region size and an aligned base address, both derived from the operation and the device geometry. The control word shows busy until the back-end answers with a done pulse. On that pulse the back-end's operation-error and low-voltage-error flags are captured into the control word, where they stay readable until the next launch. The register bus and the back-end link are plain control strobes with no back-pressure. A bus write completes in the cycle it is presented, and reads are combinational.

Top module: `nvm_keyed_ctl`

## Requirements
- R1: After reset, every readable register (control, address, data, source) reads 0 and the start pulse is low.
- R2: Control aliases are selected by offset: 0x00 replaces, 0x04 clears the bits that are 1 in the value, 0x08 sets them and 0x0C inverts them. All four offsets read the control word. Software can change only bit 14 (write enable) and bits 3:0 (operation code). Bits 13 (operation error), 12 (low-voltage error) and 11 (low-voltage status) are read-only, and every other bit except 15 reads 0.
- R3: The address register at 0x20 has the same four aliases at 0x20/0x24/0x28/0x2C. Data at 0x30 and source address at 0x40 are plain read/write words. The key port at 0x10 and any unmapped offset read 0.
- R4: The unlock is armed only by a write of 0xAA996655 to 0x10 followed directly by a write of 0x556699AA to 0x10. A wrong value, or any write to another register between the two keys, returns the sequence to its idle state.
- R5: A launch happens when a control write yields bit 15 = 1 while the unlock is armed, write enable was already 1 before that write, and no operation is running. On the next cycle bit 15 reads 1, be_start is high for exactly one cycle, and bits 13 and 12 are cleared. A write that fails any of these conditions leaves bit 15 at 0 and does not pulse be_start.
- R6: The armed unlock is consumed by any control-register write, whether or not it launches. A further launch needs both keys again.
- R7: While bit 15 is 1, it stays 1 until be_done, and writes to the control and address registers have no effect.
- R8: On be_done during an operation, bit 15 clears, be_err[0] is captured into bit 13 and be_err[1] into bit 12. Write enable and the operation code keep their values.
- R9: The back-end receives a span and an aligned base address. Operation 1 (word program) gives span 4. Operation 3 (row program) gives 512 bytes, or 128 in the small geometry. Operation 4 (page erase) gives 4096, or 1024 in the small geometry. For each of these, the base is the address rounded down to the span. Operation 5 (whole-area erase) gives span 0 and base 0.
- R10: A be_done pulse while no operation is running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 8 | Register byte offset for reads and writes |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Combinational read data for cpu_addr |
| be_start | output | 1 | One-cycle launch pulse to the back-end |
| be_op | output | 4 | Operation code of the running operation |
| be_addr | output | 32 | Base address aligned to the operation span |
| be_span | output | 16 | Region size in bytes (0 for whole area or no-op) |
| be_data | output | 32 | Word to program |
| be_src | output | 32 | Source address for row data |
| be_done | input | 1 | Completion pulse from the back-end |
| be_err | input | 2 | Completion status: bit 0 operation error, bit 1 low-voltage error |

## Verification
The bench builds two copies of the block from the same bus and back-end stimulus. One uses the default large geometry and the other sets the small-geometry parameter. Because both copies launch in the same cycles, one row-program and one page-erase launch check both the 512/4096 and the 128/1024 spans and base roundings against each other. The back-end model's latency parameter is set to eight cycles. This leaves room to attempt control and address writes while an operation is still running, and to verify that they are ignored.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_KEY  = 8'h10;
  localparam logic [7:0] OFS_ADDR = 8'h20;
  localparam logic [7:0] OFS_DATA = 8'h30;
  localparam logic [7:0] OFS_SRC  = 8'h40;

  localparam int B_BUSY  = 15;
  localparam int B_WREN  = 14;

  localparam logic [3:0] OP_WORD = 4'd1;
  localparam logic [3:0] OP_ROW  = 4'd3;
  localparam logic [3:0] OP_PAGE = 4'd4;
  localparam logic [3:0] OP_ALL  = 4'd5;

  typedef enum logic [1:0] {AL_WRITE = 2'd0, AL_CLR = 2'd1, AL_SET = 2'd2, AL_INV = 2'd3} alias_e;
  typedef enum logic [1:0] {UL_IDLE, UL_GOT1, UL_ARMED} unlock_e;

  function automatic logic [31:0] alias_apply(alias_e k, logic [31:0] cur, logic [31:0] v);
    case (k)
      AL_CLR:  return cur & ~v;
      AL_SET:  return cur | v;
      AL_INV:  return cur ^ v;
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
#(
  parameter logic [31:0] KEY_A = 32'hAA99_6655,
  parameter logic [31:0] KEY_B = 32'h5566_99AA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic        sel_key_i,
  input  logic        sel_ctrl_i,
  input  logic [31:0] wdata_i,
  output logic        armed_o
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_i) begin
      if (sel_key_i) begin
        if (st_q == UL_GOT1) st_d = (wdata_i == KEY_B) ? UL_ARMED : UL_IDLE;
        else                 st_d = (wdata_i == KEY_A) ? UL_GOT1  : UL_IDLE;
      end else if (sel_ctrl_i) begin
        st_d = UL_IDLE;
      end else if (st_q == UL_GOT1) begin
        st_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed_o = (st_q == UL_ARMED);

  // R4: arming only directly after the first key
  a_r4_arm_path: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(st_q == UL_GOT1 && wr_i && sel_key_i));
  // R4: a foreign write between the keys drops the sequence
  a_r4_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UL_GOT1 && wr_i && !sel_key_i) |=> (st_q == UL_IDLE));
  // R6: a control write uses up the unlock
  a_r6_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_ctrl_i) |=> !armed_o);
endmodule

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
  import nvm_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  alias_e      kind_i,
  input  logic [31:0] wdata_i,
  input  logic        armed_i,
  input  logic        done_i,
  input  logic [1:0]  err_i,
  output logic [31:0] word_o,
  output logic        start_o
);
  localparam int PADW = 11 - OPW;

  logic           busy_q, wren_q, err_q, lverr_q, start_q;
  logic [OPW-1:0] op_q;
  logic [31:0]    nxt;
  logic           go;
  logic           unused_nxt;

  assign word_o = {16'h0, busy_q, wren_q, err_q, lverr_q, 1'b0, {PADW{1'b0}}, op_q};
  assign nxt    = alias_apply(kind_i, word_o, wdata_i);
  assign go     = wr_i && !busy_q && armed_i && wren_q && nxt[B_BUSY];
  assign unused_nxt = ^{nxt[31:16], nxt[13:OPW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wren_q  <= 1'b0;
      err_q   <= 1'b0;
      lverr_q <= 1'b0;
      op_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (busy_q) begin
        if (done_i) begin
          busy_q  <= 1'b0;
          err_q   <= err_i[0];
          lverr_q <= err_i[1];
        end
      end else if (wr_i) begin
        wren_q <= nxt[B_WREN];
        op_q   <= nxt[OPW-1:0];
        if (go) begin
          busy_q  <= 1'b1;
          err_q   <= 1'b0;
          lverr_q <= 1'b0;
          start_q <= 1'b1;
        end
      end
    end
  end

  assign start_o = start_q;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  a_r5_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(armed_i && wr_i && wren_q));
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> busy_q);
  a_r7_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(op_q) && $stable(wren_q));
  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i) |=> !busy_q);
  a_r10_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && done_i && !wr_i) |=> (!busy_q && $stable(err_q) && $stable(lverr_q)));
endmodule

// File: rtl/nvm_geom.sv
module nvm_geom
  import nvm_pkg::*;
#(
  parameter bit SMALL_GEOM = 1'b0,
  parameter int SPAN_W     = 16
) (
  input  logic [3:0]        op_i,
  input  logic [31:0]       addr_i,
  output logic [SPAN_W-1:0] span_o,
  output logic [31:0]       base_o
);
  logic [SPAN_W-1:0] row_b, page_b, mask;

  if (SMALL_GEOM) begin : g_small
    assign row_b  = SPAN_W'(128);
    assign page_b = SPAN_W'(1024);
  end else begin : g_large
    assign row_b  = SPAN_W'(512);
    assign page_b = SPAN_W'(4096);
  end

  always_comb begin
    span_o = '0;
    case (op_i)
      OP_WORD: span_o = SPAN_W'(4);
      OP_ROW:  span_o = row_b;
      OP_PAGE: span_o = page_b;
      default: span_o = '0;
    endcase
  end

  assign mask = span_o - SPAN_W'(1);

  always_comb begin
    if (op_i == OP_ALL)     base_o = '0;
    else if (span_o != '0)  base_o = addr_i & ~{{(32-SPAN_W){1'b0}}, mask};
    else                    base_o = addr_i;
  end
endmodule

// File: rtl/nvm_keyed_ctl.sv
module nvm_keyed_ctl
  import nvm_pkg::*;
#(
  parameter bit          SMALL_GEOM = 1'b0,
  parameter int          SPAN_W     = 16,
  parameter logic [31:0] KEY_A      = 32'hAA99_6655,
  parameter logic [31:0] KEY_B      = 32'h5566_99AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              be_start,
  output logic [3:0]        be_op,
  output logic [31:0]       be_addr,
  output logic [SPAN_W-1:0] be_span,
  output logic [31:0]       be_data,
  output logic [31:0]       be_src,
  input  logic              be_done,
  input  logic [1:0]        be_err
);
  logic        sel_ctrl, sel_key, sel_addr, sel_data, sel_src;
  logic        armed, busy;
  logic [31:0] ctrl_word, addr_q, data_q, src_q;
  alias_e      kind;

  assign kind     = alias_e'(cpu_addr[3:2]);
  assign sel_ctrl = (cpu_addr[7:4] == OFS_CTRL[7:4]) && (cpu_addr[1:0] == 2'b00);
  assign sel_addr = (cpu_addr[7:4] == OFS_ADDR[7:4]) && (cpu_addr[1:0] == 2'b00);
  assign sel_key  = (cpu_addr == OFS_KEY);
  assign sel_data = (cpu_addr == OFS_DATA);
  assign sel_src  = (cpu_addr == OFS_SRC);

  nvm_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk, .rst_n,
    .wr_i       (cpu_wr),
    .sel_key_i  (sel_key),
    .sel_ctrl_i (sel_ctrl),
    .wdata_i    (cpu_wdata),
    .armed_o    (armed)
  );

  nvm_ctrl_reg #(.OPW(4)) u_ctrl (
    .clk, .rst_n,
    .wr_i    (cpu_wr && sel_ctrl),
    .kind_i  (kind),
    .wdata_i (cpu_wdata),
    .armed_i (armed),
    .done_i  (be_done),
    .err_i   (be_err),
    .word_o  (ctrl_word),
    .start_o (be_start)
  );

  assign busy  = ctrl_word[B_BUSY];
  assign be_op = ctrl_word[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      src_q  <= '0;
    end else if (cpu_wr) begin
      if (sel_addr && !busy) addr_q <= alias_apply(kind, addr_q, cpu_wdata);
      if (sel_data)          data_q <= cpu_wdata;
      if (sel_src)           src_q  <= cpu_wdata;
    end
  end

  nvm_geom #(.SMALL_GEOM(SMALL_GEOM), .SPAN_W(SPAN_W)) u_geom (
    .op_i   (be_op),
    .addr_i (addr_q),
    .span_o (be_span),
    .base_o (be_addr)
  );

  assign be_data = data_q;
  assign be_src  = src_q;

  always_comb begin
    if (sel_ctrl)      cpu_rdata = ctrl_word;
    else if (sel_addr) cpu_rdata = addr_q;
    else if (sel_data) cpu_rdata = data_q;
    else if (sel_src)  cpu_rdata = src_q;
    else               cpu_rdata = '0;
  end

  // R7: address frozen while an operation runs
  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
  // R9: base always aligned to the span handed out
  a_r9_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (be_span != '0) |-> ((be_addr & {{(32-SPAN_W){1'b0}}, be_span - SPAN_W'(1)}) == 32'h0));
  // R1: no launch pulse straight out of reset
  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !be_start);
endmodule

// File: tb/nvm_keyed_ctl_tb.sv
module nvm_keyed_ctl_tb;
  localparam int BE_LAT = 8;
  localparam logic [31:0] K1 = 32'hAA99_6655;
  localparam logic [31:0] K2 = 32'h5566_99AA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata, s_rdata;
  logic        be_start, s_start, be_done, model_done = 1'b0, spur = 1'b0;
  logic [3:0]  be_op, s_op;
  logic [31:0] be_addr, s_addr, be_data, s_data, be_src, s_src;
  logic [15:0] be_span, s_span;
  logic [1:0]  be_err = 2'b00;
  int          cnt = 0;
  int          errors = 0, checks = 0;
  bit          done_flag = 1'b0;

  always #10 clk = ~clk;

  nvm_keyed_ctl #(.SMALL_GEOM(1'b0)) u_dut (
    .clk, .rst_n, .cpu_wr, .cpu_addr, .cpu_wdata, .cpu_rdata,
    .be_start, .be_op, .be_addr, .be_span, .be_data, .be_src, .be_done, .be_err);

  nvm_keyed_ctl #(.SMALL_GEOM(1'b1)) u_small (
    .clk, .rst_n, .cpu_wr, .cpu_addr, .cpu_wdata, .cpu_rdata(s_rdata),
    .be_start(s_start), .be_op(s_op), .be_addr(s_addr), .be_span(s_span),
    .be_data(s_data), .be_src(s_src), .be_done, .be_err);

  assign be_done = model_done | spur;

  always @(negedge clk) begin
    model_done <= (cnt == 1) && !be_start;
    if (be_start)      cnt <= BE_LAT;
    else if (cnt != 0) cnt <= cnt - 1;
  end

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] ex;
    logic        r3;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_400F, 1'b0},
    '{8'h04, 32'h0000_0005, 8'h00, 32'h0000_400A, 1'b0},
    '{8'h0C, 32'h0000_4003, 8'h08, 32'h0000_0009, 1'b0},
    '{8'h08, 32'h0000_0006, 8'h0C, 32'h0000_000F, 1'b0},
    '{8'h0C, 32'h0000_0000, 8'h04, 32'h0000_000F, 1'b0},
    '{8'h20, 32'h1234_5678, 8'h20, 32'h1234_5678, 1'b1},
    '{8'h24, 32'h0000_00FF, 8'h2C, 32'h1234_5600, 1'b1},
    '{8'h28, 32'h0000_000F, 8'h20, 32'h1234_560F, 1'b1},
    '{8'h2C, 32'hFF00_0000, 8'h24, 32'hED34_560F, 1'b1},
    '{8'h30, 32'hCAFE_F00D, 8'h30, 32'hCAFE_F00D, 1'b1},
    '{8'h40, 32'h1D00_0200, 8'h40, 32'h1D00_0200, 1'b1},
    '{8'h10, K1,            8'h10, 32'h0000_0000, 1'b1},
    '{8'h50, 32'h0000_0001, 8'h50, 32'h0000_0000, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    cpu_addr = a;
    #1 v = cpu_rdata;
  endtask

  task automatic keys();
    wr(8'h10, K1);
    wr(8'h10, K2);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      rd(8'h00, v);
      if (!v[15]) break;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h20, v); chk("R1 addr", v, 32'h0);
    rd(8'h30, v); chk("R1 data", v, 32'h0);
    rd(8'h40, v); chk("R1 src", v, 32'h0);
    chk("R1 start", {31'h0, be_start}, 32'h0);
    rst_n = 1'b1;

    // R2 and R3 alias table
    foreach (VEC[i]) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, v);
      chk(VEC[i].r3 ? $sformatf("R3 vec%0d", i) : $sformatf("R2 vec%0d", i), v, VEC[i].ex);
    end

    // R5: launch without unlock is ignored
    wr(8'h00, 32'h0000_4001);
    wr(8'h08, 32'h0000_8000);
    chk("R5 no unlock start", {31'h0, be_start}, 32'h0);
    rd(8'h00, v); chk("R5 no unlock busy", v, 32'h0000_4001);

    // R4: wrong second key
    wr(8'h10, K1); wr(8'h10, 32'h1234_5678); wr(8'h10, K2);
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); chk("R4 wrong key", v, 32'h0000_4001);

    // R4: repeated first key
    wr(8'h10, K1); wr(8'h10, K1); wr(8'h10, K2);
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); chk("R4 repeated first key", v, 32'h0000_4001);

    // R4: foreign write between keys
    wr(8'h10, K1); wr(8'h30, 32'h0000_0011); wr(8'h10, K2);
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); chk("R4 foreign write", v, 32'h0000_4001);

    // R5: write enable off
    wr(8'h00, 32'h0000_0001);
    keys();
    wr(8'h08, 32'h0000_8000);
    chk("R5 wren off start", {31'h0, be_start}, 32'h0);
    rd(8'h00, v); chk("R5 wren off busy", v, 32'h0000_0001);

    // R6: control write uses up the unlock
    keys();
    wr(8'h08, 32'h0000_4000);
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); chk("R6 consumed", v, 32'h0000_4001);

    // R5/R7/R8/R9: row program, clean finish
    wr(8'h20, 32'h1D00_0ABC);
    wr(8'h30, 32'h0BAD_BEEF);
    wr(8'h00, 32'h0000_4003);
    be_err = 2'b00;
    keys();
    wr(8'h08, 32'h0000_8000);
    chk("R5 start pulse", {31'h0, be_start}, 32'h1);
    rd(8'h00, v); chk("R5 busy set", v, 32'h0000_C003);
    @(negedge clk); #1;
    chk("R5 pulse one cycle", {31'h0, be_start}, 32'h0);
    chk("R9 row span", {16'h0, be_span}, 32'd512);
    chk("R9 row base", be_addr, 32'h1D00_0A00);
    chk("R9 small row span", {16'h0, s_span}, 32'd128);
    chk("R9 small row base", s_addr, 32'h1D00_0A80);
    chk("R9 op out", {28'h0, be_op}, 32'h3);
    chk("R9 data out", be_data, 32'h0BAD_BEEF);
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h20, 32'h0000_0000);
    rd(8'h00, v); chk("R7 ctrl frozen", v, 32'h0000_C003);
    rd(8'h20, v); chk("R7 addr frozen", v, 32'h1D00_0ABC);
    wait_idle();
    rd(8'h00, v); chk("R8 clean finish", v, 32'h0000_4003);

    // R8: page erase with operation error
    be_err = 2'b01;
    wr(8'h00, 32'h0000_4004);
    keys();
    wr(8'h08, 32'h0000_8000);
    chk("R9 page span", {16'h0, be_span}, 32'd4096);
    chk("R9 page base", be_addr, 32'h1D00_0000);
    chk("R9 small page span", {16'h0, s_span}, 32'd1024);
    chk("R9 small page base", s_addr, 32'h1D00_0800);
    wait_idle();
    rd(8'h00, v); chk("R8 op error latched", v, 32'h0000_6004);
    wr(8'h04, 32'h0000_3800);
    rd(8'h00, v); chk("R2 status read-only", v, 32'h0000_6004);

    // R10: stray done while idle
    @(negedge clk); spur = 1'b1;
    @(negedge clk); spur = 1'b0;
    #1; rd(8'h00, v); chk("R10 stray done", v, 32'h0000_6004);

    // R5 clears errors on launch; R8 low-voltage error
    be_err = 2'b10;
    wr(8'h00, 32'h0000_4001);
    keys();
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, v); chk("R5 errors cleared", v, 32'h0000_C001);
    chk("R9 word span", {16'h0, be_span}, 32'd4);
    chk("R9 word base", be_addr, 32'h1D00_0ABC);
    wait_idle();
    rd(8'h00, v); chk("R8 lv error latched", v, 32'h0000_5001);

    // R9: whole-area erase
    be_err = 2'b00;
    wr(8'h00, 32'h0000_4005);
    keys();
    wr(8'h0C, 32'h0000_8000);
    chk("R9 all span", {16'h0, be_span}, 32'd0);
    chk("R9 all base", be_addr, 32'h0);
    wait_idle();
    rd(8'h00, v); chk("R8 erase finish", v, 32'h0000_4005);

    finish_run();
  end
endmodule